// File: doc/BRIEF.md
# Spare-Replicated Arithmetic Cell with Defect Bypass

This block wraps one bit-level arithmetic cell of a systolic filter array in three identical copies: a primary and two spares. It is meant only for cells whose errors could reach the protected most significant output bits of the array. Cells that feed only the low, error-tolerant outputs stay single, so the extra area is paid only where it buys yield. The wrapped cell is a gated add: the incoming partial-sum bit is added to the product of an input bit and a coefficient bit, plus a carry in. The result is registered for one cycle.

A configuration strobe latches one defect flag per copy. A priority picker then chooses the first clean copy in the order primary, spare 1, spare 2. That choice stays frozen until the next strobe. If every copy is flagged, the wrapper forces its outputs to zero and reports that it is exhausted. A per-copy fault-injection input pins a copy's results to a stuck value, so verification can show that a bypassed defect never reaches the output.

The controller is a three-state machine:
- UNSET is the state after reset, before any configuration.
- LIVE means a clean copy was found at the last load.
- EXHAUSTED means all copies were flagged at the last load.

Two transitions exist, and both can be taken from any state when the configuration strobe is high:
- LOAD_OK enters LIVE.
- LOAD_NONE enters EXHAUSTED.

Without the strobe, every state holds.

Top module: `spare_cell_guard`

## Requirements
- R1: After reset the wrapper is in UNSET. `usable`, `exhausted`, `sel_copy`, `sum_out` and `cout_out` are all 0.
- R2: In LIVE, one clock edge after the data inputs are applied, `sum_out` equals psum XOR (xbit AND cbit) XOR carry. `cout_out` equals the majority of psum, (xbit AND cbit) and carry.
- R3: On a configuration strobe with at least one flag clear, the next state is LIVE. `sel_copy` becomes the lowest index whose flag `cfg_defect[i]` is 0, where index 0 is the primary, 1 is spare 1 and 2 is spare 2. The selected copy's latched flag is always clear.
- R4: On a strobe with all flags set (`cfg_defect` = 3'b111), the next state is EXHAUSTED, with `exhausted`=1 and `usable`=0. `sum_out` and `cout_out` stay 0 whatever the data and injection inputs are.
- R5: Changing `cfg_defect` without a strobe changes neither `sel_copy` nor the state.
- R6: A stuck fault injected (`inject_en[i]`=1) on any copy other than the selected one has no effect on `sum_out`/`cout_out`. The Hamming distance of the outputs against the correct result stays 0.
- R7: A fault injected on the selected copy forces both `sum_out` and `cout_out` to `inject_val` one edge later.
- R8: While `usable` is 0, `sum_out` and `cout_out` are 0 after the next edge. This covers UNSET, so data applied before any configuration is not passed on.
- R9: A new strobe while LIVE or EXHAUSTED re-runs the selection, and the wrapper moves to the state and copy that the new flags dictate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Configuration strobe that latches the defect flags |
| cfg_defect | input | NSPARE+1 | Per-copy defect flags; bit 0 is the primary |
| inject_en | input | NSPARE+1 | Per-copy stuck-fault injection enable |
| inject_val | input | 1 | Stuck value for injected copies |
| psum_in | input | 1 | Incoming partial-sum bit |
| xbit_in | input | 1 | Input word bit |
| cbit_in | input | 1 | Coefficient bit |
| carry_in | input | 1 | Carry in |
| sum_out | output | 1 | Registered sum bit |
| cout_out | output | 1 | Registered carry out |
| sel_copy | output | clog2(NSPARE+1) | Index of the copy that drives the output |
| usable | output | 1 | High in LIVE |
| exhausted | output | 1 | High in EXHAUSTED |

## Verification
The bench builds the wrapper with its default of two spares, so there are three copies. That makes all eight flag patterns reachable, and each one sets the priority outcome or the exhausted state directly. With three copies, stuck faults can be placed on bypassed copies alone, on the selected copy, or on every copy. The full 16-combination truth table of the gated add is then checked under each selection.

// File: rtl/spare_guard_pkg.sv
package spare_guard_pkg;

    typedef enum logic [1:0] {
        GS_UNSET     = 2'd0,
        GS_LIVE      = 2'd1,
        GS_EXHAUSTED = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } bit_result_t;

endpackage

// File: rtl/gated_add_cell.sv
module gated_add_cell
    import spare_guard_pkg::*;
(
    input  logic        psum_i,
    input  logic        xbit_i,
    input  logic        cbit_i,
    input  logic        carry_i,
    output bit_result_t res_o
);
    logic prod;

    always_comb begin
        prod        = xbit_i & cbit_i;
        res_o.sum   = psum_i ^ prod ^ carry_i;
        res_o.carry = (psum_i & prod) | (psum_i & carry_i) | (prod & carry_i);
    end
endmodule

// File: rtl/copy_picker.sv
module copy_picker #(
    parameter int NCOPY = 3,
    parameter int SELW  = 2
) (
    input  logic [NCOPY-1:0] bad_i,
    output logic [SELW-1:0]  pick_o,
    output logic             found_o
);
    // The scan runs from the highest index down, so the lowest clean index wins.
    always_comb begin
        pick_o  = '0;
        found_o = 1'b0;
        for (int i = NCOPY - 1; i >= 0; i--) begin
            if (!bad_i[i]) begin
                pick_o  = SELW'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
    import spare_guard_pkg::*;
#(
    parameter int NCOPY = 3,
    parameter int SELW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [NCOPY-1:0] cfg_defect,
    input  logic [SELW-1:0]  pick_i,
    input  logic             found_i,
    output logic [NCOPY-1:0] flags_q,
    output logic [SELW-1:0]  sel_q,
    output logic             usable_o,
    output logic             exhausted_o
);
    guard_state_e state_q, state_d;

    // Next state: LOAD_OK and LOAD_NONE are both taken from any state on a strobe.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_UNSET, GS_LIVE, GS_EXHAUSTED: begin
                if (cfg_load) begin
                    state_d = found_i ? GS_LIVE : GS_EXHAUSTED;
                end
            end
            default: state_d = GS_UNSET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_UNSET;
            flags_q <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_load) begin
                flags_q <= cfg_defect;
                sel_q   <= pick_i;
            end
        end
    end

    always_comb begin
        usable_o    = 1'b0;
        exhausted_o = 1'b0;
        unique case (state_q)
            GS_UNSET:     ;
            GS_LIVE:      usable_o    = 1'b1;
            GS_EXHAUSTED: exhausted_o = 1'b1;
            default:      ;
        endcase
    end

    // R5: without a strobe, the selection and the state hold.
    p_sel_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(sel_q) && $stable(state_q)));

    // R3: a strobe that finds a clean copy leads to LIVE.
    p_load_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && found_i) |=> usable_o);

    // R4: a strobe with every flag set leads to EXHAUSTED.
    p_load_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (&cfg_defect)) |=> (exhausted_o && !usable_o));
endmodule

// File: rtl/spare_cell_guard.sv
module spare_cell_guard
    import spare_guard_pkg::*;
#(
    parameter int NSPARE = 2,
    localparam int NCOPY = NSPARE + 1,
    localparam int SELW  = (NCOPY > 1) ? $clog2(NCOPY) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [NCOPY-1:0] cfg_defect,
    input  logic [NCOPY-1:0] inject_en,
    input  logic             inject_val,
    input  logic             psum_in,
    input  logic             xbit_in,
    input  logic             cbit_in,
    input  logic             carry_in,
    output logic             sum_out,
    output logic             cout_out,
    output logic [SELW-1:0]  sel_copy,
    output logic             usable,
    output logic             exhausted
);
    bit_result_t      copy_res [NCOPY];
    logic [SELW-1:0]  pick;
    logic             found;
    logic [NCOPY-1:0] flags_q;

    for (genvar g = 0; g < NCOPY; g++) begin : g_copy
        bit_result_t raw;

        gated_add_cell u_cell (
            .psum_i  (psum_in),
            .xbit_i  (xbit_in),
            .cbit_i  (cbit_in),
            .carry_i (carry_in),
            .res_o   (raw)
        );

        // A stuck-at overlay placed on this copy alone.
        always_comb begin
            if (inject_en[g]) begin
                copy_res[g] = '{carry: inject_val, sum: inject_val};
            end else begin
                copy_res[g] = raw;
            end
        end
    end

    copy_picker #(.NCOPY(NCOPY), .SELW(SELW)) u_picker (
        .bad_i   (cfg_defect),
        .pick_o  (pick),
        .found_o (found)
    );

    guard_ctrl #(.NCOPY(NCOPY), .SELW(SELW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_load    (cfg_load),
        .cfg_defect  (cfg_defect),
        .pick_i      (pick),
        .found_i     (found),
        .flags_q     (flags_q),
        .sel_q       (sel_copy),
        .usable_o    (usable),
        .exhausted_o (exhausted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_out  <= 1'b0;
            cout_out <= 1'b0;
        end else if (usable) begin
            sum_out  <= copy_res[sel_copy].sum;
            cout_out <= copy_res[sel_copy].carry;
        end else begin
            sum_out  <= 1'b0;
            cout_out <= 1'b0;
        end
    end

    // R3: the driving copy is never one that was flagged as defective.
    p_sel_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        usable |-> !flags_q[sel_copy]);

    // R8 and R4: a non-live wrapper presents zeros after the next edge.
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !usable |=> (!sum_out && !cout_out));
endmodule

// File: tb/test_spare_cell_guard.sv
module test_spare_cell_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [2:0] cfg_defect = '0;
    logic [2:0] inject_en = '0;
    logic       inject_val = 1'b0;
    logic       psum_in = 1'b0;
    logic       xbit_in = 1'b0;
    logic       cbit_in = 1'b0;
    logic       carry_in = 1'b0;
    logic       sum_out, cout_out, usable, exhausted;
    logic [1:0] sel_copy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spare_cell_guard i_spare_cell_guard (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_defect(cfg_defect),
        .inject_en(inject_en), .inject_val(inject_val), .psum_in(psum_in),
        .xbit_in(xbit_in), .cbit_in(cbit_in), .carry_in(carry_in),
        .sum_out(sum_out), .cout_out(cout_out), .sel_copy(sel_copy),
        .usable(usable), .exhausted(exhausted)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input logic [3:0] v);
        logic p;
        p = v[1] & v[2];
        return {(v[0] & p) | (v[0] & v[3]) | (p & v[3]), v[0] ^ p ^ v[3]};
    endfunction

    task automatic configure(input logic [2:0] f);
        @(negedge clk);
        cfg_defect = f;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Bit 0 = psum, bit 1 = xbit, bit 2 = cbit, bit 3 = carry.
    task automatic apply(input logic [3:0] v);
        @(negedge clk);
        {carry_in, cbit_in, xbit_in, psum_in} = v;
        @(negedge clk);
    endtask

    task automatic sweep_ok(input string req);
        for (int v = 0; v < 16; v++) begin
            logic [1:0] e;
            apply(4'(v));
            e = model(4'(v));
            chk(req, 8'($countones({cout_out, sum_out} ^ e)), 8'd0);
        end
    endtask

    task automatic t_reset;
        chk("R1 usable", {7'd0, usable}, 8'd0);
        chk("R1 exhausted", {7'd0, exhausted}, 8'd0);
        chk("R1 sel", {6'd0, sel_copy}, 8'd0);
        chk("R1 outputs", {6'd0, cout_out, sum_out}, 8'd0);
        apply(4'b1111);
        chk("R8 unconfigured outputs", {6'd0, cout_out, sum_out}, 8'd0);
    endtask

    task automatic t_priority;
        for (int f = 0; f < 8; f++) begin
            logic [1:0] es;
            es = (f[0] == 1'b0) ? 2'd0 : (f[1] == 1'b0) ? 2'd1 : (f[2] == 1'b0) ? 2'd2 : 2'd0;
            configure(3'(f));
            if (f != 7) begin
                chk("R3 usable", {7'd0, usable}, 8'd1);
                chk("R3 sel", {6'd0, sel_copy}, {6'd0, es});
            end else begin
                chk("R4 exhausted", {7'd0, exhausted}, 8'd1);
                chk("R4 usable", {7'd0, usable}, 8'd0);
            end
        end
    endtask

    task automatic t_function;
        configure(3'b000);
        sweep_ok("R2 primary");
        configure(3'b101);
        sweep_ok("R2 spare1");
    endtask

    task automatic t_latch;
        configure(3'b000);
        @(negedge clk);
        cfg_defect = 3'b111;
        repeat (3) @(negedge clk);
        chk("R5 sel held", {6'd0, sel_copy}, 8'd0);
        chk("R5 still usable", {7'd0, usable}, 8'd1);
        apply(4'b0111);
        chk("R5 data", {6'd0, cout_out, sum_out}, {6'd0, model(4'b0111)});
    endtask

    task automatic t_bypass;
        configure(3'b001);
        inject_en = 3'b001;
        inject_val = 1'b1;
        sweep_ok("R6 primary stuck1");
        configure(3'b011);
        inject_en = 3'b011;
        inject_val = 1'b0;
        sweep_ok("R6 two stuck0");
        inject_en = 3'b000;
    endtask

    task automatic t_visible;
        configure(3'b000);
        inject_en = 3'b001;
        inject_val = 1'b1;
        apply(4'b0000);
        chk("R7 stuck1", {6'd0, cout_out, sum_out}, 8'd3);
        inject_val = 1'b0;
        apply(4'b1111);
        chk("R7 stuck0", {6'd0, cout_out, sum_out}, 8'd0);
        inject_en = 3'b000;
    endtask

    task automatic t_dead;
        configure(3'b111);
        inject_en = 3'b111;
        inject_val = 1'b1;
        apply(4'b1111);
        chk("R4 outputs zero", {6'd0, cout_out, sum_out}, 8'd0);
        chk("R4 exhausted flag", {7'd0, exhausted}, 8'd1);
        inject_en = 3'b000;
    endtask

    task automatic t_reconfig;
        configure(3'b111);
        configure(3'b100);
        chk("R9 revive usable", {7'd0, usable}, 8'd1);
        chk("R9 revive sel", {6'd0, sel_copy}, 8'd0);
        apply(4'b1011);
        chk("R9 revive data", {6'd0, cout_out, sum_out}, {6'd0, model(4'b1011)});
        configure(3'b011);
        chk("R9 move sel", {6'd0, sel_copy}, 8'd2);
        configure(3'b111);
        chk("R9 to exhausted", {7'd0, exhausted}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_function();
        t_latch();
        t_bypass();
        t_visible();
        t_dead();
        t_reconfig();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule